// File: doc/BRIEF.md
# Pipelined Serial ADC Readout Model

This block is a synthesizable model of the digital side of a sampling converter with a three-wire serial port. A host drives an active-low chip select and a serial clock. The model answers on a single data output. A parallel input word stands in for the analog value the converter would produce. The model uses the serial clock edges both to complete a conversion and to shift out data. Counting falling edges within one chip-select-low frame decides whether a conversion finishes.

Readout is pipelined by one frame. The word shifted out during a frame is the result of the conversion performed in the previous frame. After power-up that result is zero. A frame that ends too early poisons the result the next frame will carry: a fixed marker code goes out and a flag output is raised. The model runs on its own fast system clock. It resynchronises chip select and serial clock, so it can serve as a bench partner or in an emulator.

Top module: `adcser_model`

## Requirements
- R1: While chip select is high (after the synchroniser delay), `sdo_en` is 0 and `sdo` is 0.
- R2: When chip select falls, `sdo_en` goes to 1 and `sdo` holds 0 until the first serial clock rising edge that follows a falling edge.
- R3: Data leaves MSB first. Bit 13 appears on the first rising edge after the first falling edge of the frame, and each later rising edge brings the next lower bit, down to bit 0.
- R4: After all 14 data bits have gone out, `sdo` is 0 on every further rising edge of the frame.
- R5: The word shifted out in a frame is the one captured during the previous frame that completed its conversion.
- R6: After reset, the first frame reads out all zeros with `rd_bad` low.
- R7: A frame that ends with fewer than 18 falling edges makes the next frame read out the marker code 0x2AAA with `rd_bad` at 1. `rd_bad` is 0 in frames that follow a completed conversion, and it is constant for the whole frame.
- R8: The input word is captured at the first falling edge of the frame. Changes to it later in the same frame have no effect on the result.
- R9: The conversion completes on the 18th falling edge. Further falling edges in that frame neither recount nor alter the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-up) |
| cs_n | input | 1 | Chip select from the host, active low, asynchronous |
| sclk | input | 1 | Serial clock from the host, idles high, asynchronous |
| smp_word | input | 14 | Parallel word standing in for the converted value |
| sdo | output | 1 | Serial data towards the host |
| sdo_en | output | 1 | Output enable for sdo; 0 means the line is released |
| rd_bad | output | 1 | High during a frame whose data is the invalid marker |

## Verification
The model is run through a sequence of frames whose input words carry distinct bit patterns. A wrong bit order, a dropped bit or a one-frame misalignment therefore shows up as a different word. Full 18-edge frames check the one-frame pipeline and the power-up zero. A 10-edge frame and a 20-edge frame separate the poisoned path from the saturating, still-valid one. One frame changes the input word right after its first falling edge, which shows whether the capture happens at that edge and nowhere later.

// File: rtl/adcser_pkg.sv
package adcser_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_CONV = 2'd1,
        PH_ACQ  = 2'd2
    } phase_e;

    typedef struct packed {
        logic cs_lo;
        logic cs_fall;
        logic cs_rise;
        logic sck_fall;
        logic sck_rise;
    } pin_ev_t;

endpackage

// File: rtl/adcser_sync.sv
module adcser_sync
    import adcser_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    cs_n,
    input  logic    sclk,
    output pin_ev_t ev
);
    localparam int NPIN   = 2;
    localparam int PIN_SK = 0;
    localparam int PIN_CS = 1;

    typedef struct packed {
        logic [NPIN-1:0][STAGES-1:0] chain;
        logic [NPIN-1:0]             prev;
    } sync_st_t;

    sync_st_t s_d, s_q;
    logic [NPIN-1:0] raw;
    logic [NPIN-1:0] settled;

    assign raw[PIN_SK] = sclk;
    assign raw[PIN_CS] = cs_n;

    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        assign settled[g] = s_q.chain[g][STAGES-1];
    end

    always_comb begin
        s_d = s_q;
        for (int p = 0; p < NPIN; p++) begin
            s_d.chain[p] = {s_q.chain[p][STAGES-2:0], raw[p]};
            s_d.prev[p]  = settled[p];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        ev.cs_lo    = !settled[PIN_CS];
        ev.cs_fall  = s_q.prev[PIN_CS] && !settled[PIN_CS];
        ev.cs_rise  = !s_q.prev[PIN_CS] && settled[PIN_CS];
        ev.sck_fall = !settled[PIN_CS] && s_q.prev[PIN_SK] && !settled[PIN_SK];
        ev.sck_rise = !settled[PIN_CS] && !s_q.prev[PIN_SK] && settled[PIN_SK];
    end

endmodule

// File: rtl/adcser_frame.sv
module adcser_frame
    import adcser_pkg::*;
#(
    parameter int              DATA_W     = 14,
    parameter int              CONV_EDGES = 18,
    parameter logic [DATA_W-1:0] BAD_CODE = 14'h2AAA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  pin_ev_t           ev,
    input  logic [DATA_W-1:0] smp_word,
    output logic [DATA_W-1:0] result,
    output logic              result_bad,
    output phase_e            phase,
    output logic [$clog2(CONV_EDGES+1)-1:0] fall_cnt
);
    localparam int CW = $clog2(CONV_EDGES + 1);
    localparam logic [CW-1:0] LAST_EDGE = CW'(CONV_EDGES - 1);

    typedef struct packed {
        phase_e            phase;
        logic [CW-1:0]     cnt;
        logic [DATA_W-1:0] hold;
        logic [DATA_W-1:0] result;
        logic              bad;
    } frm_st_t;

    frm_st_t f_d, f_q;
    logic [DATA_W-1:0] conv_word;

    always_comb begin
        f_d       = f_q;
        conv_word = f_q.hold;

        if (ev.cs_fall) begin
            f_d.cnt   = '0;
            f_d.phase = PH_CONV;
        end

        if (ev.sck_fall && f_q.phase == PH_CONV) begin
            if (f_q.cnt == '0) begin
                conv_word = smp_word;
                f_d.hold  = smp_word;
            end
            f_d.cnt = f_q.cnt + 1'b1;
            if (f_q.cnt == LAST_EDGE) begin
                f_d.result = conv_word;
                f_d.bad    = 1'b0;
                f_d.phase  = PH_ACQ;
            end
        end

        if (ev.cs_rise) begin
            if (f_q.phase == PH_CONV) begin
                f_d.result = BAD_CODE;
                f_d.bad    = 1'b1;
            end
            f_d.phase = PH_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '{phase: PH_IDLE, cnt: '0, hold: '0, result: '0, bad: 1'b0};
        end else begin
            f_q <= f_d;
        end
    end

    assign result     = f_q.result;
    assign result_bad = f_q.bad;
    assign phase      = f_q.phase;
    assign fall_cnt   = f_q.cnt;

endmodule

// File: rtl/adcser_shift.sv
module adcser_shift
    import adcser_pkg::*;
#(
    parameter int DATA_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  pin_ev_t           ev,
    input  logic [DATA_W-1:0] result,
    input  logic              result_bad,
    output logic              sdo,
    output logic              sdo_en,
    output logic              rd_bad,
    output logic              tail
);
    localparam int SW = $clog2(DATA_W + 1);
    localparam logic [SW-1:0] ALL_SENT = SW'(DATA_W);

    typedef struct packed {
        logic [DATA_W-1:0] sh;
        logic              sdo;
        logic              en;
        logic              rbad;
        logic              armed;
        logic [SW-1:0]     sent;
        logic              tail;
    } shf_st_t;

    shf_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;

        if (ev.cs_fall) begin
            s_d.sh    = result;
            s_d.sdo   = 1'b0;
            s_d.en    = 1'b1;
            s_d.rbad  = result_bad;
            s_d.armed = 1'b0;
            s_d.sent  = '0;
            s_d.tail  = 1'b0;
        end

        if (ev.sck_fall) begin
            s_d.armed = 1'b1;
        end

        if (ev.sck_rise && s_q.armed) begin
            s_d.sdo = s_q.sh[DATA_W-1];
            s_d.sh  = {s_q.sh[DATA_W-2:0], 1'b0};
            if (s_q.sent == ALL_SENT) begin
                s_d.tail = 1'b1;
            end else begin
                s_d.sent = s_q.sent + 1'b1;
            end
        end

        if (ev.cs_rise) begin
            s_d.sdo   = 1'b0;
            s_d.en    = 1'b0;
            s_d.rbad  = 1'b0;
            s_d.armed = 1'b0;
            s_d.tail  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sdo    = s_q.sdo;
    assign sdo_en = s_q.en;
    assign rd_bad = s_q.rbad;
    assign tail   = s_q.tail;

endmodule

// File: rtl/adcser_model.sv
module adcser_model
    import adcser_pkg::*;
#(
    parameter int                DATA_W      = 14,
    parameter int                CONV_EDGES  = 18,
    parameter int                SYNC_STAGES = 2,
    parameter logic [DATA_W-1:0] BAD_CODE    = 14'h2AAA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic [DATA_W-1:0] smp_word,
    output logic              sdo,
    output logic              sdo_en,
    output logic              rd_bad
);
    localparam int CW = $clog2(CONV_EDGES + 1);

    pin_ev_t           ev;
    logic [DATA_W-1:0] result;
    logic              result_bad;
    phase_e            phase;
    logic [CW-1:0]     fall_cnt;
    logic              tail;
    logic              cs_lo;

    assign cs_lo = ev.cs_lo;

    adcser_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .cs_n  (cs_n),
        .sclk  (sclk),
        .ev    (ev)
    );

    adcser_frame #(
        .DATA_W     (DATA_W),
        .CONV_EDGES (CONV_EDGES),
        .BAD_CODE   (BAD_CODE)
    ) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev         (ev),
        .smp_word   (smp_word),
        .result     (result),
        .result_bad (result_bad),
        .phase      (phase),
        .fall_cnt   (fall_cnt)
    );

    adcser_shift #(
        .DATA_W (DATA_W)
    ) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev         (ev),
        .result     (result),
        .result_bad (result_bad),
        .sdo        (sdo),
        .sdo_en     (sdo_en),
        .rd_bad     (rd_bad),
        .tail       (tail)
    );

endmodule

// File: rtl/adcser_chk.sv
module adcser_chk
    import adcser_pkg::*;
#(
    parameter int CONV_EDGES = 18,
    parameter int CW         = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_lo,
    input logic          sdo,
    input logic          sdo_en,
    input logic          rd_bad,
    input logic          tail,
    input phase_e        phase,
    input logic [CW-1:0] fall_cnt
);

    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n) (!cs_lo && $past(!cs_lo)) |-> !sdo_en); // R1
    AST_IDLE_PIN_LOW: assert property (@(posedge clk) disable iff (!rst_n) !sdo_en |-> !sdo); // R1
    AST_FRAME_STARTS_LOW: assert property (@(posedge clk) disable iff (!rst_n) $rose(sdo_en) |-> !sdo); // R2
    AST_TAIL_ZERO: assert property (@(posedge clk) disable iff (!rst_n) tail |-> !sdo); // R4
    AST_BAD_FLAG_STEADY: assert property (@(posedge clk) disable iff (!rst_n) (sdo_en && $past(sdo_en)) |-> $stable(rd_bad)); // R7
    AST_EDGE_CNT_CAP: assert property (@(posedge clk) disable iff (!rst_n) fall_cnt <= CW'(CONV_EDGES)); // R9
    AST_ACQ_AFTER_FULL: assert property (@(posedge clk) disable iff (!rst_n) phase == PH_ACQ |-> fall_cnt == CW'(CONV_EDGES)); // R9

endmodule

bind adcser_model adcser_chk #(
    .CONV_EDGES (CONV_EDGES),
    .CW         (CW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_lo    (cs_lo),
    .sdo      (sdo),
    .sdo_en   (sdo_en),
    .rd_bad   (rd_bad),
    .tail     (tail),
    .phase    (phase),
    .fall_cnt (fall_cnt)
);

// File: tb/sim_adcser_model.sv
module sim_adcser_model;
    localparam int DW    = 14;
    localparam int HOLD  = 6;
    localparam logic [DW-1:0] BAD = 14'h2AAA;

    typedef struct {
        int    sig;
        logic  val;
        string req;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sclk = 1'b1;
    logic [DW-1:0] smp_word = '0;
    logic sdo, sdo_en, rd_bad;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    exp_t exp_q[$];
    event chk_ev;

    always #2 clk = ~clk;

    adcser_model u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .sclk     (sclk),
        .smp_word (smp_word),
        .sdo      (sdo),
        .sdo_en   (sdo_en),
        .rd_bad   (rd_bad)
    );

    task automatic expect_sig(input int sig, input logic val, input string req);
        exp_t e;
        e.sig = sig;
        e.val = val;
        e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: pops every pending expectation and compares with the pins
    initial begin
        forever begin
            @(chk_ev);
            while (exp_q.size() > 0) begin
                exp_t e;
                logic act;
                e = exp_q.pop_front();
                act = (e.sig == 0) ? sdo : (e.sig == 1) ? sdo_en : rd_bad;
                n_chk++;
                if (act !== e.val) begin
                    n_bad++;
                    $display("FAIL %s sig=%0d actual=%b expected=%b at %0t", e.req, e.sig, act, e.val, $time);
                end
            end
        end
    end

    // driver: one frame with nclk serial clocks; alt replaces the input after the first falling edge
    task automatic run_frame(input logic [DW-1:0] word, input logic [DW-1:0] alt, input int nclk,
                             input logic [DW-1:0] exp_word, input logic exp_bad, input string req);
        smp_word = word;
        cs_n = 1'b0;
        wait_n(HOLD);
        expect_sig(1, 1'b1, "R2");
        expect_sig(0, 1'b0, "R2");
        expect_sig(2, exp_bad, req);
        -> chk_ev;
        for (int i = 1; i <= nclk; i++) begin
            sclk = 1'b0;
            wait_n(HOLD);
            if (i == 1) smp_word = alt;
            sclk = 1'b1;
            wait_n(HOLD);
            if (i <= DW) expect_sig(0, exp_word[DW-i], req);
            else         expect_sig(0, 1'b0, "R4");
            expect_sig(2, exp_bad, "R7");
            -> chk_ev;
        end
        cs_n = 1'b1;
        wait_n(HOLD);
        expect_sig(1, 1'b0, "R1");
        expect_sig(0, 1'b0, "R1");
        -> chk_ev;
        wait_n(HOLD);
    endtask

    initial begin
        wait_n(3);
        expect_sig(1, 1'b0, "R1");
        expect_sig(0, 1'b0, "R1");
        expect_sig(2, 1'b0, "R6");
        -> chk_ev;
        rst_n = 1'b1;
        wait_n(HOLD);
        // R6: first frame reads zero; captures 0x1234
        run_frame(14'h1234, 14'h1234, 18, 14'h0000, 1'b0, "R6");
        // R3 R5: previous word out MSB first
        run_frame(14'h2DCB, 14'h2DCB, 18, 14'h1234, 1'b0, "R3");
        // R7: short frame of 10 edges, still shows the previous word
        run_frame(14'h0F0F, 14'h0F0F, 10, 14'h2DCB, 1'b0, "R5");
        // R7: marker code after short frame; R9: 20 edges complete normally
        run_frame(14'h3FFF, 14'h3FFF, 20, BAD, 1'b1, "R7");
        run_frame(14'h0001, 14'h0001, 18, 14'h3FFF, 1'b0, "R9");
        // R8: input changes after first fall must be ignored
        run_frame(14'h1555, 14'h0AAA, 18, 14'h0001, 1'b0, "R5");
        run_frame(14'h2001, 14'h2001, 18, 14'h1555, 1'b0, "R8");
        run_frame(14'h0000, 14'h0000, 16, 14'h2001, 1'b0, "R3");
        run_frame(14'h0000, 14'h0000, 18, BAD, 1'b1, "R7");
        wait_n(2);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule